// File: doc/BRIEF.md
# Plasma Panel Subfield Drive Sequencer

This block times one subfield of a plasma display that keeps addressing and light emission in separate periods. A `frame_start` pulse begins the subfield. First every scan row is driven to a set level at once, which clears and presets all cells. Then the rows are addressed one at a time, from row 0 upward. While a row holds the select level, the column bus carries that row's one-bit-per-column word: a 1 primes the cell and a 0 leaves it unprimed. Rows that are already addressed rest at a base-write level so that they cannot erase themselves. Rows not yet reached stay idle. The common sustain electrode sits at a sub-write level for the whole address period.

After the last row is addressed, all scan rows and the common electrode receive sustain pulse trains in opposite phase. A one-cycle `subfield_done` pulse follows, and the block waits for the next `frame_start`. Row words come in over a ready/valid handshake, one word per select slot. If the word is late, the sequencer waits at the start of that slot.

All outputs are symbolic 3-bit level codes for external high-voltage drivers: IDLE=0, SET=1, SELECT=2, BASE_WRITE=3, SUS_HI=4, SUS_LO=5, SUB_WRITE=6. Scan row r occupies bits [3r+2:3r] of `scan_lvl`.

Top module: `pdp_subfield_seq`

## Requirements
- R1: A `frame_start` seen while idle drives SET (1) on every scan row for exactly SET_CYC cycles, beginning the next cycle.
- R2: During addressing at most one row is at SELECT (2). Rows are selected in ascending order starting at 0, and each select lasts exactly SEL_CYC cycles.
- R3: While a row is at SELECT, `col_data` equals the word accepted for that row.
- R4: During addressing, rows below the current row are at BASE_WRITE (3) and rows above it are at IDLE (0).
- R5: `com_lvl` is SUB_WRITE (6) whenever any row is at SELECT or BASE_WRITE.
- R6: Sustain starts only after all ROWS rows are addressed. All scan rows then carry the same level, alternating SUS_HI (4) and SUS_LO (5) and beginning with SUS_HI, while `com_lvl` carries the opposite level.
- R7: `col_data` is 0 in every cycle in which no row is at SELECT.
- R8: Each sustain half-period lasts SUS_W cycles, and there are exactly SUS_PULSES SUS_HI halves on the scan rows. The default SUS_W of 450 gives 4.5 us at a 100 MHz clock.
- R9: `subfield_done` is high for exactly one cycle, in the cycle right after the last sustain half. It is never high at any other time.
- R10: A `frame_start` that arrives while a subfield is in progress has no effect: no extra set period follows, and the number of set periods equals the number of `frame_start` pulses given while idle.
- R11: `row_ready` is high only while waiting at the start of a select slot, and no row is at SELECT while waiting. The select begins in the cycle after a cycle with `row_ready` and `row_valid` both high.
- R12: After reset, all scan rows and `com_lvl` are IDLE, and `col_data`, `row_ready` and `subfield_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a subfield when idle |
| row_data | input | COLS | One-bit-plane word for the next row |
| row_valid | input | 1 | Row word is valid |
| row_ready | output | 1 | Sequencer accepts a row word |
| scan_lvl | output | 3*ROWS | Level code per scan row |
| com_lvl | output | 3 | Level code of the common electrode |
| col_data | output | COLS | Column address data |
| subfield_done | output | 1 | One-cycle end-of-subfield pulse |

## Verification
Row words are drawn at random and mixed with all-zero, all-one and alternating words. These show that each select carries its own row's word and not a neighbour's or a stale one. Handshake stalls range from none, so slots run back to back, to long waits. This separates a sequencer that waits correctly from one that selects early or skips a row. Extra `frame_start` pulses during addressing and during sustain check that a subfield in progress cannot be restarted. A monitor measures every set, select and sustain run length, which exposes any off-by-one error in the phase counters.

// File: rtl/pdp_seq_pkg.sv
package pdp_seq_pkg;
   typedef enum logic [2:0] {
      LV_IDLE   = 3'd0,
      LV_SET    = 3'd1,
      LV_SELECT = 3'd2,
      LV_BASEW  = 3'd3,
      LV_SUS_HI = 3'd4,
      LV_SUS_LO = 3'd5,
      LV_SUBW   = 3'd6
   } lvl_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SET  = 3'd1,
      ST_WAIT = 3'd2,
      ST_SEL  = 3'd3,
      ST_SUS  = 3'd4,
      ST_DONE = 3'd5
   } st_e;

   localparam int LVW = 3;
endpackage

// File: rtl/pdp_seq_ctrl.sv
module pdp_seq_ctrl
   import pdp_seq_pkg::*;
#(
   parameter int ROWS       = 8,
   parameter int SET_CYC    = 20,
   parameter int SEL_CYC    = 4,
   parameter int SUS_W      = 450,
   parameter int SUS_PULSES = 4,
   localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CMAX   = (SET_CYC > SEL_CYC) ? ((SET_CYC > SUS_W) ? SET_CYC : SUS_W)
                                               : ((SEL_CYC > SUS_W) ? SEL_CYC : SUS_W),
   localparam int CW     = $clog2(CMAX + 1),
   localparam int HALVES = 2 * SUS_PULSES,
   localparam int HW     = $clog2(HALVES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          row_valid,
   output st_e           state,
   output logic [RW-1:0] row_idx,
   output logic          half_lo,
   output logic          row_ready,
   output logic          load,
   output logic          done
);
   st_e           st_q;
   logic [CW-1:0] cnt_q;
   logic [RW-1:0] row_q;
   logic          half_q;
   logic [HW-1:0] hcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         row_q  <= '0;
         half_q <= 1'b0;
         hcnt_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (frame_start) begin
                  st_q  <= ST_SET;
                  cnt_q <= '0;
               end
            end
            ST_SET: begin
               if (cnt_q == CW'(SET_CYC - 1)) begin
                  st_q  <= ST_WAIT;
                  cnt_q <= '0;
                  row_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WAIT: begin
               if (row_valid) begin
                  st_q  <= ST_SEL;
                  cnt_q <= '0;
               end
            end
            ST_SEL: begin
               if (cnt_q == CW'(SEL_CYC - 1)) begin
                  cnt_q <= '0;
                  if (row_q == RW'(ROWS - 1)) begin
                     st_q   <= ST_SUS;
                     half_q <= 1'b0;
                     hcnt_q <= '0;
                  end else begin
                     row_q <= row_q + 1'b1;
                     st_q  <= ST_WAIT;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_SUS: begin
               if (cnt_q == CW'(SUS_W - 1)) begin
                  cnt_q  <= '0;
                  half_q <= ~half_q;
                  if (hcnt_q == HW'(HALVES - 1)) st_q <= ST_DONE;
                  else                           hcnt_q <= hcnt_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign state     = st_q;
   assign row_idx   = row_q;
   assign half_lo   = half_q;
   assign row_ready = (st_q == ST_WAIT);
   assign load      = (st_q == ST_WAIT) && row_valid;
   assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/pdp_row_buf.sv
module pdp_row_buf #(
   parameter int COLS      = 16,
   parameter bit BUF_CLEAR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            sel_active,
   input  logic [COLS-1:0] row_data,
   output logic [COLS-1:0] col_data
);
   logic [COLS-1:0] buf_q;

   generate
      if (BUF_CLEAR) begin : g_clear
         // the word is dropped once its select slot ends
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          buf_q <= '0;
            else if (load)       buf_q <= row_data;
            else if (!sel_active) buf_q <= '0;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    buf_q <= '0;
            else if (load) buf_q <= row_data;
         end
      end
   endgenerate

   assign col_data = sel_active ? buf_q : '0;
endmodule

// File: rtl/pdp_level_map.sv
module pdp_level_map
   import pdp_seq_pkg::*;
#(
   parameter int ROWS = 8,
   localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  st_e                 state,
   input  logic [RW-1:0]       row_idx,
   input  logic                half_lo,
   output logic [LVW*ROWS-1:0] scan_lvl,
   output logic [LVW-1:0]      com_lvl
);
   lvl_e sus_scan, sus_com;
   assign sus_scan = half_lo ? LV_SUS_LO : LV_SUS_HI;
   assign sus_com  = half_lo ? LV_SUS_HI : LV_SUS_LO;

   genvar r;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         lvl_e lv;
         always_comb begin
            lv = LV_IDLE;
            case (state)
               ST_SET:  lv = LV_SET;
               ST_WAIT: lv = (r < int'(row_idx)) ? LV_BASEW : LV_IDLE;
               ST_SEL: begin
                  if (r < int'(row_idx))       lv = LV_BASEW;
                  else if (r == int'(row_idx)) lv = LV_SELECT;
                  else                         lv = LV_IDLE;
               end
               ST_SUS:  lv = sus_scan;
               default: lv = LV_IDLE;
            endcase
         end
         assign scan_lvl[r*LVW +: LVW] = lv;
      end
   endgenerate

   always_comb begin
      case (state)
         ST_WAIT, ST_SEL: com_lvl = LV_SUBW;
         ST_SUS:          com_lvl = sus_com;
         default:         com_lvl = LV_IDLE;
      endcase
   end
endmodule

// File: rtl/pdp_subfield_seq.sv
module pdp_subfield_seq
   import pdp_seq_pkg::*;
#(
   parameter int ROWS       = 8,
   parameter int COLS       = 16,
   parameter int SET_CYC    = 20,
   parameter int SEL_CYC    = 4,
   parameter int CLK_MHZ    = 100,
   parameter int SUS_W      = 450,  // 4.5 us at 100 MHz
   parameter int SUS_PULSES = 4,
   parameter bit BUF_CLEAR  = 1'b1,
   localparam int RW        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [COLS-1:0]   row_data,
   input  logic              row_valid,
   output logic              row_ready,
   output logic [3*ROWS-1:0] scan_lvl,
   output logic [2:0]        com_lvl,
   output logic [COLS-1:0]   col_data,
   output logic              subfield_done
);
   generate
      if (ROWS < 1)       begin : g_bad_rows  $error("ROWS must be at least 1"); end
      if (COLS < 1)       begin : g_bad_cols  $error("COLS must be at least 1"); end
      if (SET_CYC < 1)    begin : g_bad_set   $error("SET_CYC must be at least 1"); end
      if (SEL_CYC < 1)    begin : g_bad_sel   $error("SEL_CYC must be at least 1"); end
      if (SUS_PULSES < 1) begin : g_bad_pul   $error("SUS_PULSES must be at least 1"); end
      if (SUS_W < 4 * CLK_MHZ || SUS_W > 5 * CLK_MHZ) begin : g_bad_w
         $error("SUS_W must give a 4 to 5 us pulse at CLK_MHZ");
      end
   endgenerate

   st_e           state;
   logic [RW-1:0] row_idx;
   logic          half_lo;
   logic          load;

   pdp_seq_ctrl #(
      .ROWS(ROWS), .SET_CYC(SET_CYC), .SEL_CYC(SEL_CYC),
      .SUS_W(SUS_W), .SUS_PULSES(SUS_PULSES)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_valid(row_valid),
      .state(state), .row_idx(row_idx), .half_lo(half_lo),
      .row_ready(row_ready), .load(load), .done(subfield_done)
   );

   pdp_row_buf #(.COLS(COLS), .BUF_CLEAR(BUF_CLEAR)) i_buf (
      .clk(clk), .rst_n(rst_n), .load(load), .sel_active(state == ST_SEL),
      .row_data(row_data), .col_data(col_data)
   );

   pdp_level_map #(.ROWS(ROWS)) i_map (
      .state(state), .row_idx(row_idx), .half_lo(half_lo),
      .scan_lvl(scan_lvl), .com_lvl(com_lvl)
   );
endmodule

// File: rtl/pdp_seq_chk.sv
module pdp_seq_chk
   import pdp_seq_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              row_ready,
   input logic              subfield_done,
   input logic [3*ROWS-1:0] scan_lvl,
   input logic [2:0]        com_lvl,
   input logic [COLS-1:0]   col_data
);
   logic [ROWS-1:0] sel_vec;
   logic [ROWS-1:0] bw_vec;
   always_comb begin
      for (int r = 0; r < ROWS; r++) begin
         sel_vec[r] = (scan_lvl[3*r +: 3] == LV_SELECT);
         bw_vec[r]  = (scan_lvl[3*r +: 3] == LV_BASEW);
      end
   end

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_vec) <= 1) else $error("two rows selected");   // R2
   AST_COL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vec == '0) |-> (col_data == '0)) else $error("column data leak"); // R7
   AST_COM_SUBW: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_vec | bw_vec) != '0) |-> (com_lvl == LV_SUBW)) else $error("common not sub-write"); // R5
   AST_SUS_ANTI: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_lvl[2:0] == LV_SUS_HI) |-> (com_lvl == LV_SUS_LO)) else $error("sustain not anti-phase"); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      subfield_done |=> !subfield_done) else $error("done longer than one cycle"); // R9
   AST_WAIT_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      row_ready |-> (sel_vec == '0)) else $error("select during wait"); // R11
endmodule

bind pdp_subfield_seq pdp_seq_chk #(.ROWS(ROWS), .COLS(COLS)) i_chk (
   .clk(clk), .rst_n(rst_n), .row_ready(row_ready), .subfield_done(subfield_done),
   .scan_lvl(scan_lvl), .com_lvl(com_lvl), .col_data(col_data)
);

// File: tb/test_pdp_subfield_seq.sv
module test_pdp_subfield_seq;
   localparam int ROWS = 8, COLS = 16, SET_CYC = 20, SEL_CYC = 4;
   localparam int SUS_W = 450, SUS_PULSES = 4;
   localparam logic [2:0] L_IDLE = 0, L_SET = 1, L_SEL = 2, L_BW = 3,
                          L_HI = 4, L_LO = 5, L_SUBW = 6;

   logic              clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, row_valid = 1'b0;
   logic [COLS-1:0]   row_data = '0;
   logic              row_ready, subfield_done;
   logic [3*ROWS-1:0] scan_lvl;
   logic [2:0]        com_lvl;
   logic [COLS-1:0]   col_data;

   int checks = 0, errors = 0;
   logic [COLS-1:0] exp_row [ROWS];
   int idle_starts = 0, set_starts = 0, dones = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pdp_subfield_seq i_pdp_subfield_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_data(row_data),
      .row_valid(row_valid), .row_ready(row_ready), .scan_lvl(scan_lvl),
      .com_lvl(com_lvl), .col_data(col_data), .subfield_done(subfield_done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] lvl(input int r);
      return scan_lvl[3*r +: 3];
   endfunction

   // monitor state
   bit mon_on = 0;
   int set_run = 0, sel_run = 0, sel_prev = -1, next_row = 0;
   int sus_run = 0, hi_cnt = 0;
   bit prev_sus = 0, hs_pend = 0;
   logic [2:0] sus_prev = 0;

   always @(negedge clk) if (mon_on) begin
      int n_sel, sel_idx, n_set, n_hi, n_lo;
      bit in_sus, left_sus;
      n_sel = 0; sel_idx = -1; n_set = 0; n_hi = 0; n_lo = 0;
      for (int r = 0; r < ROWS; r++) begin
         if (lvl(r) == L_SEL) begin n_sel++; sel_idx = r; end
         if (lvl(r) == L_SET) n_set++;
         if (lvl(r) == L_HI)  n_hi++;
         if (lvl(r) == L_LO)  n_lo++;
      end
      // R1 set period
      if (n_set > 0) begin
         if (set_run == 0) begin set_starts++; next_row = 0; end
         set_run++;
         if (set_run == 1) chk(n_set == ROWS && com_lvl == L_IDLE, "R1", n_set, ROWS);
      end else if (set_run > 0) begin
         chk(set_run == SET_CYC, "R1", set_run, SET_CYC);
         set_run = 0;
      end
      // R11 select follows a handshake
      if (hs_pend) chk(n_sel == 1, "R11", n_sel, 1);
      hs_pend = row_ready && row_valid;
      if (row_ready) begin
         chk(n_sel == 0, "R11", n_sel, 0);
         for (int r = 0; r < ROWS; r++)
            if (lvl(r) != ((r < next_row) ? L_BW : L_IDLE))
               chk(0, "R4", lvl(r), (r < next_row) ? L_BW : L_IDLE);
      end
      // R2 R3 R4 R7 addressing
      if (n_sel > 1) chk(0, "R2", n_sel, 1);
      if (n_sel == 1) begin
         if (sel_idx != sel_prev) begin
            chk(sel_idx == next_row, "R2", sel_idx, next_row);
            next_row++;
            sel_run = 0;
         end
         sel_run++;
         chk(col_data == exp_row[sel_idx], "R3", col_data, exp_row[sel_idx]);
         for (int r = 0; r < ROWS; r++)
            if (lvl(r) != ((r < sel_idx) ? L_BW : (r == sel_idx) ? L_SEL : L_IDLE))
               chk(0, "R4", lvl(r), r < sel_idx ? L_BW : L_IDLE);
      end else begin
         if (col_data != '0) chk(0, "R7", col_data, 0);
      end
      if (sel_prev >= 0 && sel_idx != sel_prev)
         chk(sel_run == SEL_CYC || sel_idx >= 0, "R2", sel_run, SEL_CYC);
      if (n_sel == 1 && sel_idx != sel_prev && sel_prev >= 0) begin end
      if (sel_prev >= 0 && n_sel == 0) chk(sel_run == SEL_CYC, "R2", sel_run, SEL_CYC);
      sel_prev = sel_idx;
      // R5
      for (int r = 0; r < ROWS; r++)
         if ((lvl(r) == L_SEL || lvl(r) == L_BW) && com_lvl != L_SUBW) begin
            chk(0, "R5", com_lvl, L_SUBW);
            break;
         end
      // R6 R8 sustain
      in_sus = (n_hi + n_lo) > 0;
      if (in_sus) begin
         if (!(n_hi == ROWS || n_lo == ROWS)) chk(0, "R6", n_hi, ROWS);
         if (com_lvl != ((n_hi > 0) ? L_LO : L_HI)) chk(0, "R6", com_lvl, (n_hi > 0) ? L_LO : L_HI);
         if (!prev_sus) begin
            chk(next_row == ROWS && n_hi == ROWS, "R6", next_row, ROWS);
            hi_cnt = 1; sus_run = 1;
         end else if (lvl(0) == sus_prev) begin
            sus_run++;
         end else begin
            chk(sus_run == SUS_W, "R8", sus_run, SUS_W);
            sus_run = 1;
            if (n_hi > 0) hi_cnt++;
         end
         sus_prev = lvl(0);
      end
      left_sus = prev_sus && !in_sus;
      if (left_sus) begin
         chk(sus_run == SUS_W, "R8", sus_run, SUS_W);
         chk(hi_cnt == SUS_PULSES, "R8", hi_cnt, SUS_PULSES);
         chk(subfield_done == 1'b1, "R9", subfield_done, 1);
      end else if (subfield_done) begin
         chk(0, "R9", subfield_done, 0);
      end
      if (subfield_done) dones++;
      prev_sus = in_sus;
   end

   task automatic send_row(input int r, input logic [COLS-1:0] d, input int stall, input bit inject);
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         frame_start = inject && (i == 0);
      end
      @(negedge clk);
      frame_start = 1'b0;
      exp_row[r] = d;
      row_data   = d;
      row_valid  = 1'b1;
      while (!row_ready) @(negedge clk);
      @(negedge clk);
      row_valid = 1'b0;
      row_data  = $urandom;
   endtask

   // mode: 0 random, 1 zeros, 2 ones, 3 alternating
   task automatic run_subfield(input int mode, input int max_stall, input bit inject);
      int tick;
      @(negedge clk);
      frame_start = 1'b1;
      idle_starts++;
      @(negedge clk);
      frame_start = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
         logic [COLS-1:0] d;
         case (mode)
            1: d = '0;
            2: d = '1;
            3: d = (r % 2) ? {(COLS/2){2'b10}} : {(COLS/2){2'b01}};
            default: d = COLS'($urandom);
         endcase
         send_row(r, d, (max_stall > 0) ? int'($urandom_range(0, max_stall)) : 0, inject && r == 3);
      end
      tick = 0;
      while (!subfield_done) begin
         @(negedge clk);
         tick++;
         frame_start = inject && (tick == 700);  // R10: pulse during sustain
      end
      frame_start = 1'b0;
      repeat (5) @(negedge clk);
      // R10 remains idle without a fresh start
      chk(scan_lvl == '0 && com_lvl == L_IDLE, "R10", scan_lvl, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(scan_lvl == '0, "R12", scan_lvl, 0);
      chk(com_lvl == L_IDLE, "R12", com_lvl, L_IDLE);
      chk(col_data == '0 && row_ready == 1'b0 && subfield_done == 1'b0, "R12", col_data, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      repeat (2) @(negedge clk);
      run_subfield(0, 0, 0);   // back-to-back slots
      run_subfield(1, 3, 1);   // zeros, stalls, extra starts
      run_subfield(2, 6, 0);   // ones
      run_subfield(3, 2, 1);   // alternating words
      run_subfield(0, 30, 0);  // long stalls
      run_subfield(0, 4, 1);
      chk(set_starts == idle_starts, "R10", set_starts, idle_starts);
      chk(dones == idle_starts, "R9", dones, idle_starts);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule